// File: doc/BRIEF.md
# Circular Buffer Pointer Updater

This block produces the next value of an address pointer that walks a circular buffer. Each request carries the current pointer, a signed step, a packed modifier word and a separate buffer-start word. The block adds the step to the pointer in 32-bit arithmetic. If the sum has left the buffer, it adds or subtracts the buffer length once to bring the sum back inside.

Two ways of locating the buffer are supported. The modifier word selects between them. In the aligned mode the buffer lies on a power-of-two boundary. Its base is the pointer with its low bits cleared, and the size exponent in the modifier sets how many bits are cleared. In the explicit mode the base is the separate start word, and the limit is that base plus the length. The result is registered by default, which gives a one-cycle request-to-result latency with a valid flag. Setting a parameter makes the path purely combinational.

Top module: `circ_ptr_update`

## Requirements
- R1: The buffer length is modifier bits [16:0] and the size exponent K is modifier bits [27:24]. Bits [23:17] and [31:28] have no effect on the result.
- R2: The candidate is pointer plus step, modulo 2^32. The step is two's-complement. A candidate that is at or above the base and below the limit is returned unchanged.
- R3: When K is nonzero (aligned mode), the base is the pointer with its low K+2 bits cleared, and the limit is the base bitwise-ORed with the length.
- R4: A candidate at or above the limit (unsigned compare) has the length subtracted once.
- R5: A candidate below the base (unsigned compare) that is not at or above the limit has the length added once. The limit test takes priority.
- R6: When K is zero and the length is 4 or more (explicit mode), the base is the start word and the limit is the start word plus the length, added modulo 2^32 rather than ORed.
- R7: When K is zero and the length is below 4, the aligned formulas apply with the low 2 bits cleared.
- R8: The result always equals the candidate, the candidate minus the length, or the candidate plus the length.
- R9: With the output register on, out_valid is 0 and ptr_o is 0 in reset. After reset, out_valid in each cycle equals in_valid of the previous cycle, and the result of an accepted request appears one cycle after it.
- R10: While in_valid is low, ptr_o holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| ptr_i | input | 32 | Current pointer |
| step_i | input | 32 | Signed step added to the pointer |
| modifier_i | input | 32 | Packed length [16:0] and size exponent [27:24] |
| start_i | input | 32 | Buffer start word used in explicit mode |
| out_valid | output | 1 | Result valid |
| ptr_o | output | 32 | Updated, wrapped pointer |

## Verification
On every cycle, the checker enforces four properties: the one-cycle valid pipeline, the holding of the result while idle, the rule that each result differs from the raw sum by zero or exactly one length, and the pass-through of a zero step inside an explicit-mode buffer. Which of the three outcomes is correct depends on how the base and limit are formed in each mode. That includes the difference between an ORed and an added limit, the masking of the pointer's low bits, the narrow mode with a length below 4, and the ignored modifier bits. Only the scenario checks, with their hand-worked expected pointers, can show these.

// File: rtl/circ_pkg.sv
package circ_pkg;
  typedef enum logic {
    LOC_ALIGNED  = 1'b0,
    LOC_EXPLICIT = 1'b1
  } circ_loc_e;

  localparam int unsigned EXPLICIT_MIN_LEN = 4;
  localparam int unsigned MASK_EXTRA_BITS  = 2;
endpackage

// File: rtl/circ_field_decode.sv
module circ_field_decode
  import circ_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 17,
  parameter int unsigned K_LSB = 24,
  parameter int unsigned K_W   = 4
) (
  input  logic [AW-1:0]  modifier_i,
  output logic [AW-1:0]  len_o,
  output logic [K_W-1:0] kexp_o,
  output circ_loc_e      loc_o
);
  localparam int unsigned K_MSB = K_LSB + K_W - 1;

  logic unused_fields;
  assign unused_fields = ^{modifier_i[AW-1:K_MSB+1], modifier_i[K_LSB-1:LEN_W]};

  always_comb begin
    len_o  = AW'(modifier_i[LEN_W-1:0]);
    kexp_o = modifier_i[K_MSB:K_LSB];
    if ((kexp_o == '0) && (len_o >= AW'(EXPLICIT_MIN_LEN)))
      loc_o = LOC_EXPLICIT;
    else
      loc_o = LOC_ALIGNED;
  end
endmodule

// File: rtl/circ_bounds.sv
module circ_bounds
  import circ_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned K_W = 4
) (
  input  circ_loc_e      loc_i,
  input  logic [K_W-1:0] kexp_i,
  input  logic [AW-1:0]  len_i,
  input  logic [AW-1:0]  ptr_i,
  input  logic [AW-1:0]  start_i,
  output logic [AW-1:0]  base_o,
  output logic [AW-1:0]  limit_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] shamt;
  logic [AW-1:0] low_mask;

  always_comb begin
    shamt    = AW'(kexp_i) + AW'(MASK_EXTRA_BITS);
    low_mask = (ONE << shamt) - ONE;
    if (loc_i == LOC_EXPLICIT) begin
      base_o  = start_i;
      limit_o = start_i + len_i;
    end else begin
      base_o  = ptr_i & ~low_mask;
      limit_o = base_o | len_i;
    end
  end
endmodule

// File: rtl/circ_wrap.sv
module circ_wrap #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0] cand;

  always_comb begin
    cand = ptr_i + step_i;
    if (cand >= limit_i)
      next_o = cand - len_i;
    else if (cand < base_i)
      next_o = cand + len_i;
    else
      next_o = cand;
  end
endmodule

// File: rtl/circ_ptr_update.sv
module circ_ptr_update
  import circ_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned LEN_W   = 17,
  parameter int unsigned K_LSB   = 24,
  parameter int unsigned K_W     = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] modifier_i,
  input  logic [AW-1:0] start_i,
  output logic          out_valid,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0]  len_w;
  logic [K_W-1:0] kexp_w;
  circ_loc_e      loc_w;
  logic [AW-1:0]  base_w;
  logic [AW-1:0]  limit_w;
  logic [AW-1:0]  next_w;

  circ_field_decode #(.AW(AW), .LEN_W(LEN_W), .K_LSB(K_LSB), .K_W(K_W)) u_dec (
    .modifier_i (modifier_i),
    .len_o      (len_w),
    .kexp_o     (kexp_w),
    .loc_o      (loc_w)
  );

  circ_bounds #(.AW(AW), .K_W(K_W)) u_bnd (
    .loc_i   (loc_w),
    .kexp_i  (kexp_w),
    .len_i   (len_w),
    .ptr_i   (ptr_i),
    .start_i (start_i),
    .base_o  (base_w),
    .limit_o (limit_w)
  );

  circ_wrap #(.AW(AW)) u_wrap (
    .ptr_i   (ptr_i),
    .step_i  (step_i),
    .len_i   (len_w),
    .base_i  (base_w),
    .limit_i (limit_w),
    .next_o  (next_w)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic          vld_q, vld_d;
      logic [AW-1:0] res_q, res_d;

      always_comb begin
        vld_d = in_valid;
        res_d = in_valid ? next_w : res_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
        end else begin
          vld_q <= vld_d;
          res_q <= res_d;
        end
      end

      assign out_valid = vld_q;
      assign ptr_o     = res_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_valid  = in_valid;
      assign ptr_o      = next_w;
    end
  endgenerate
endmodule

// File: rtl/circ_ptr_update_chk.sv
module circ_ptr_update_chk #(
  parameter int unsigned AW      = 32,
  parameter int unsigned LEN_W   = 17,
  parameter int unsigned K_LSB   = 24,
  parameter int unsigned K_W     = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [AW-1:0] ptr_i,
  input logic [AW-1:0] step_i,
  input logic [AW-1:0] modifier_i,
  input logic [AW-1:0] start_i,
  input logic          out_valid,
  input logic [AW-1:0] ptr_o
);
  logic [AW-1:0] raw_sum;
  logic [AW-1:0] span;
  logic [AW:0]   ext_end;
  logic          expl_idle_in;

  assign raw_sum = ptr_i + step_i;
  assign span    = AW'(modifier_i[LEN_W-1:0]);
  assign ext_end = {1'b0, start_i} + {1'b0, span};
  assign expl_idle_in = (modifier_i[K_LSB+K_W-1:K_LSB] == '0) && (span >= AW'(4)) &&
                        (step_i == '0) && (ptr_i >= start_i) &&
                        ({1'b0, ptr_i} < ext_end) && !ext_end[AW];

  generate
    if (REG_OUT) begin : g_chk
      // R9
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R9
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R10
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ptr_o));
      // R8
      single_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (ptr_o == $past(raw_sum)) ||
                     (ptr_o == $past(raw_sum) - $past(span)) ||
                     (ptr_o == $past(raw_sum) + $past(span)));
      // R6
      explicit_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && expl_idle_in) |=> (ptr_o == $past(ptr_i)));
    end
  endgenerate
endmodule

bind circ_ptr_update circ_ptr_update_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .ptr_i      (ptr_i),
  .step_i     (step_i),
  .modifier_i (modifier_i),
  .start_i    (start_i),
  .out_valid  (out_valid),
  .ptr_o      (ptr_o)
);

// File: tb/sim_circ_ptr_update.sv
module sim_circ_ptr_update;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] ptr_i, step_i, modifier_i, start_i;
  logic        out_valid;
  logic [31:0] ptr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit mon_en = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  circ_ptr_update u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ptr_i(ptr_i),
    .step_i(step_i), .modifier_i(modifier_i), .start_i(start_i),
    .out_valid(out_valid), .ptr_o(ptr_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] p, input logic [31:0] s, input logic [31:0] m,
                      input logic [31:0] st, input logic [31:0] exp, input string tag);
    @(negedge clk);
    ptr_i = p; step_i = s; modifier_i = m; start_i = st; in_valid = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Scoreboard monitor: one result per out_valid, compared in order.
  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected out_valid", {31'b0, out_valid}, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(ptr_o === e, t, ptr_o, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    ptr_i = '0; step_i = '0; modifier_i = '0; start_i = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R9 reset out_valid", {31'b0, out_valid}, 32'h0);
    check(ptr_o === 32'h0, "R9 reset ptr_o", ptr_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;

    // aligned K=2, len 12: base 0x10000000, limit 0x1000000C
    send(32'h1000_0004, 32'h4, 32'h0200_000C, 32'h0, 32'h1000_0008, "R2 R3 inside");
    send(32'h1000_0008, 32'h4, 32'h0200_000C, 32'h0, 32'h1000_0000, "R4 at limit");
    send(32'h1000_0000, 32'hFFFF_FFFC, 32'h0200_000C, 32'h0, 32'h1000_0008, "R5 below base");
    // same as the limit case with junk in bits [31:28] and [23:17]
    send(32'h1000_0008, 32'h4, 32'hF2FE_000C, 32'h0, 32'h1000_0000, "R1 ignored bits");
    // explicit: start 0x20000030, len 0x64, limit 0x20000094 (OR would give ...74)
    send(32'h2000_0080, 32'h8, 32'h0000_0064, 32'h2000_0030, 32'h2000_0088, "R6 added limit");
    send(32'h2000_0030, 32'hFFFF_FFF8, 32'h0000_0064, 32'h2000_0030, 32'h2000_008C, "R6 below start");
    send(32'h2000_0090, 32'h8, 32'h0000_0064, 32'h2000_0030, 32'h2000_0034, "R6 above limit");
    send(32'h2000_0050, 32'h0, 32'h0000_0064, 32'h2000_0030, 32'h2000_0050, "R6 zero step");
    // K=0, len 3: aligned with mask 3; start word is ignored
    send(32'h4000_0001, 32'h2, 32'h0000_0003, 32'h5000_0000, 32'h4000_0000, "R7 short length");
    send(32'h4000_0002, 32'h0, 32'h0000_0003, 32'h5000_0000, 32'h4000_0002, "R7 inside");
    // K=10, len 0x800: base 0x30005000, limit 0x30005800
    send(32'h3000_57F0, 32'h20, 32'h0A00_0800, 32'h0, 32'h3000_5010, "R3 R4 wide K");

    @(negedge clk);
    in_valid = 1'b0;
    ptr_i = 32'hDEAD_BEEF; step_i = 32'h1234; modifier_i = 32'h0300_0010; start_i = 32'h77;
    // last result appears at this edge; then hold
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      ptr_i = ptr_i + 32'h100;
      check(out_valid === 1'b0, "R9 idle out_valid", {31'b0, out_valid}, 32'h0);
      check(ptr_o === 32'h3000_5010, "R10 hold", ptr_o, 32'h3000_5010);
    end
    check(exp_q.size() == 0, "R9 results drained", exp_q.size(), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule